// File: doc/BRIEF.md
# Dual-Mode Synthesizer Configuration Loader

This block keeps the divider settings that steer a frequency synthesizer: a 9-bit feedback divider, two 3-bit output post-dividers (A and B), a 4-bit select field and a 2-bit test field. The PLL, the dividers themselves and any frequency arithmetic live elsewhere. The block only decides which setting is active at any moment.

Settings arrive on one of two paths that share the same active registers. On the parallel path, a load strobe makes the block transparent while it is low and freezes the inputs on its rising edge. The serial path works only while that strobe is high. Bits are clocked into a 21-bit shift register on a serial clock, and a separate transfer pulse then copies the decoded fields into the active registers. A flag reports whether the active feedback divider lies outside a legal window set by parameters.

All inputs are taken as already synchronous to the system clock. The serial clock, the transfer pulse and the parallel strobe are edge-detected inside the block. The parallel path is tracked by a two-state machine. In `ST_TRACK` the strobe was low on the previous cycle, so every cycle captures the parallel inputs. `ST_HOLD` means the strobe was high, so the registers hold. The `capture` transition goes from `ST_TRACK` to `ST_HOLD` on a high strobe. The `release` transition goes from `ST_HOLD` to `ST_TRACK` on a low strobe. Reset enters `ST_HOLD`.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset the active values are feedback 160, post-dividers A and B 0, select 0, test 0, and the shift register holds all zeros. A transfer issued before any shift therefore loads all zeros.
- R2: While the strobe `par_load` is low, `act_m`, `act_na` and `act_nb` equal `par_m`, `par_na` and `par_nb` in the same cycle. The 2-bit post-divider inputs are zero-extended to 3 bits. Select and test keep their stored values.
- R3: On the clock where `par_load` is first seen high, the parallel inputs present in that cycle are stored. They stay active for as long as the strobe remains high, whatever the inputs do afterwards.
- R4: A rising edge of `ser_clk` while `par_load` is high shifts `ser_data` into bit 0 of the 21-bit shift register. Shifting alone never changes any output.
- R5: The stream is sent most significant bit first within each field. The order is select (4 bits), test (2), B post-divider (3), A post-divider (3), then feedback divider (9). After 21 shifts the word has select in bits 20:17, test in 16:15, B in 14:12, A in 11:9 and feedback in 8:0.
- R6: A rising edge of `ser_xfer` while `par_load` is high, in a cycle that is not a strobe capture, copies all five fields into the active registers. The new values are visible after that clock.
- R7: While `par_load` is low, serial clocks and transfer pulses are ignored. They change neither the shift register nor select and test.
- R8: When the strobe capture and a transfer edge fall in the same cycle, the parallel capture wins. The transfer is dropped and select and test stay unchanged.
- R9: When a shift edge and a transfer edge fall in the same cycle, the transfer copies the shift-register content from before that shift. The shift still takes place.
- R10: `m_out_of_range` is 1 exactly when `act_m` is below `M_MIN` (default 140) or above `M_MAX` (default 175). Both bounds are legal values.
- R11: A level held high on `ser_clk` or `ser_xfer` acts once, at its rising edge only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_load | input | 1 | Parallel strobe: low = transparent, rising = capture, high = serial enabled |
| par_m | input | 9 | Parallel feedback divider |
| par_na | input | 2 | Parallel post-divider A |
| par_nb | input | 2 | Parallel post-divider B |
| ser_clk | input | 1 | Serial shift clock (edge-detected) |
| ser_data | input | 1 | Serial data bit |
| ser_xfer | input | 1 | Serial transfer pulse (edge-detected) |
| act_m | output | 9 | Active feedback divider |
| act_na | output | 3 | Active post-divider A |
| act_nb | output | 3 | Active post-divider B |
| act_sel | output | 4 | Active select field |
| act_test | output | 2 | Active test field |
| m_out_of_range | output | 1 | Active feedback divider outside legal window |

## Verification
Two pairs of functions can collide in one cycle.

- **Strobe capture with transfer:** the bench raises the strobe and the transfer pulse on the same clock, after loading a distinct word into the shift register. The check confirms that the parallel value is active and that select and test are untouched.
- **Shift with transfer:** the last bit of a word is sent together with a transfer pulse. The active fields are compared against the word that the register held one shift earlier. A following transfer then shows that the final shift was still applied.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    localparam int M_W   = 9;
    localparam int NO_W  = 3;
    localparam int NP_W  = 2;
    localparam int SEL_W = 4;
    localparam int TST_W = 2;
    localparam int SR_W  = SEL_W + TST_W + 2 * NO_W + M_W;

    // Field order equals serial arrival order: first bits end up highest.
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [TST_W-1:0] tst;
        logic [NO_W-1:0]  nb;
        logic [NO_W-1:0]  na;
        logic [M_W-1:0]   m;
    } cfg_t;

    typedef enum logic {
        ST_TRACK = 1'b0,
        ST_HOLD  = 1'b1
    } ld_state_e;
endpackage

// File: rtl/synth_cfg_edge.sv
module synth_cfg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

    // R11: a held level yields no second edge
    a_r11_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/synth_cfg_shifter.sv
module synth_cfg_shifter #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[W-2:0], din};
    end

    // R4: new bit enters at position 0, older bits move up
    a_r4_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word[0] == $past(din)) && (word[W-1:1] == $past(word[W-2:0])));
endmodule

// File: rtl/synth_cfg_range.sv
module synth_cfg_range #(
    parameter int W   = 9,
    parameter int LO  = 140,
    parameter int HI  = 175
) (
    input  logic [W-1:0] value,
    output logic         outside
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    assign outside = (value < LO_V) || (value > HI_V);
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import synth_cfg_pkg::*;
#(
    parameter int M_RESET = 160,
    parameter int M_MIN   = 140,
    parameter int M_MAX   = 175
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_load,
    input  logic [M_W-1:0]   par_m,
    input  logic [NP_W-1:0]  par_na,
    input  logic [NP_W-1:0]  par_nb,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_xfer,
    output logic [M_W-1:0]   act_m,
    output logic [NO_W-1:0]  act_na,
    output logic [NO_W-1:0]  act_nb,
    output logic [SEL_W-1:0] act_sel,
    output logic [TST_W-1:0] act_test,
    output logic             m_out_of_range
);
    localparam int EXT_W = NO_W - NP_W;

    ld_state_e state_q, state_d;
    cfg_t      cur_q;
    cfg_t      sr_cfg;
    logic [SR_W-1:0] sr_word;
    logic      sclk_rise, xfer_rise;
    logic      par_cap, xfer_go;

    synth_cfg_edge u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .lvl(ser_clk), .rise(sclk_rise)
    );
    synth_cfg_edge u_xfer_edge (
        .clk(clk), .rst_n(rst_n), .lvl(ser_xfer), .rise(xfer_rise)
    );

    synth_cfg_shifter #(.W(SR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (par_load & sclk_rise),
        .din      (ser_data),
        .word     (sr_word)
    );

    assign sr_cfg = cfg_t'(sr_word);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Transition and control decode
    always_comb begin
        state_d = state_q;
        par_cap = 1'b0;
        xfer_go = 1'b0;
        unique case (state_q)
            ST_TRACK: begin
                par_cap = 1'b1;              // tracking, or capture on rise
                if (par_load) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!par_load) begin
                    par_cap = 1'b1;
                    state_d = ST_TRACK;      // release
                end else begin
                    xfer_go = xfer_rise;
                end
            end
        endcase
    end

    // Active registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.m   <= M_W'(M_RESET);
            cur_q.na  <= '0;
            cur_q.nb  <= '0;
            cur_q.sel <= '0;
            cur_q.tst <= '0;
        end else if (par_cap) begin
            cur_q.m  <= par_m;
            cur_q.na <= {{EXT_W{1'b0}}, par_na};
            cur_q.nb <= {{EXT_W{1'b0}}, par_nb};
        end else if (xfer_go) begin
            cur_q <= sr_cfg;
        end
    end

    // Outputs: transparent while strobe low
    always_comb begin
        act_sel  = cur_q.sel;
        act_test = cur_q.tst;
        if (!par_load) begin
            act_m  = par_m;
            act_na = {{EXT_W{1'b0}}, par_na};
            act_nb = {{EXT_W{1'b0}}, par_nb};
        end else begin
            act_m  = cur_q.m;
            act_na = cur_q.na;
            act_nb = cur_q.nb;
        end
    end

    synth_cfg_range #(.W(M_W), .LO(M_MIN), .HI(M_MAX)) u_range (
        .value   (act_m),
        .outside (m_out_of_range)
    );

    // R3: first high cycle of the strobe stores the parallel inputs
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK && par_load) |=> (act_m == $past(par_m)) || !par_load);

    // R4: held strobe without transfer edge keeps the settings
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && par_load && !xfer_rise) |=> $stable(cur_q));

    // R6: transfer copies select from the shift register
    a_r6_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |=> (act_sel == $past(sr_word[SR_W-1 -: SEL_W])));

    // R8: capture beats a simultaneous transfer
    a_r8_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK && par_load && xfer_rise) |=> $stable(act_sel) && $stable(act_test));

    // R7: serial activity while strobe low leaves select untouched
    a_r7_low_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        !par_load |=> $stable(act_sel) && $stable(act_test));
endmodule

// File: tb/test_synth_cfg_loader.sv
module test_synth_cfg_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_load = 1'b1;
    logic [8:0] par_m = '0;
    logic [1:0] par_na = '0, par_nb = '0;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_xfer = 1'b0;
    logic [8:0] act_m;
    logic [2:0] act_na, act_nb;
    logic [3:0] act_sel;
    logic [1:0] act_test;
    logic       m_out_of_range;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    synth_cfg_loader i_synth_cfg_loader (
        .clk(clk), .rst_n(rst_n), .par_load(par_load),
        .par_m(par_m), .par_na(par_na), .par_nb(par_nb),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_xfer(ser_xfer),
        .act_m(act_m), .act_na(act_na), .act_nb(act_nb),
        .act_sel(act_sel), .act_test(act_test),
        .m_out_of_range(m_out_of_range)
    );

    localparam int NV = 8;
    localparam int VM  [NV] = '{139, 140, 175, 176, 160, 0, 511, 150};
    localparam int VNA [NV] = '{0, 1, 2, 3, 0, 3, 1, 3};
    localparam int VNB [NV] = '{3, 2, 1, 0, 0, 3, 2, 2};
    localparam int VOOR[NV] = '{1, 0, 0, 1, 0, 1, 1, 0};

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_data = b; ser_clk = 1'b1;
        step();
        ser_clk = 1'b0;
        step();
    endtask

    task automatic send_word(input logic [20:0] w);
        for (int i = 20; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_xfer();
        ser_xfer = 1'b1;
        step();
        ser_xfer = 1'b0;
        step();
    endtask

    task automatic chk_all(input string tag, input logic [20:0] w);
        chk({tag, " sel"},  int'(act_sel),  int'(w[20:17]));
        chk({tag, " test"}, int'(act_test), int'(w[16:15]));
        chk({tag, " nb"},   int'(act_nb),   int'(w[14:12]));
        chk({tag, " na"},   int'(act_na),   int'(w[11:9]));
        chk({tag, " m"},    int'(act_m),    int'(w[8:0]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [20:0] w2, w3, w4, pre, post;
        w2 = {4'hA, 2'd2, 3'd5, 3'd6, 9'd333};
        w3 = {4'h5, 2'd1, 3'd7, 3'd3, 9'd400};
        w4 = {4'h9, 2'd3, 3'd2, 3'd4, 9'd145};

        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk_all("R1 reset", {4'd0, 2'd0, 3'd0, 3'd0, 9'd160});
        chk("R10 reset in range", int'(m_out_of_range), 0);
        pulse_xfer();
        chk_all("R1 cleared shift reg", 21'd0);
        chk("R10 m=0 flag", int'(m_out_of_range), 1);

        // R2 / R10 transparent vector table
        for (int k = 0; k < NV; k++) begin
            par_load = 1'b0;
            par_m = 9'(VM[k]); par_na = 2'(VNA[k]); par_nb = 2'(VNB[k]);
            #2;
            chk("R2 transparent m",  int'(act_m),  VM[k]);
            chk("R2 transparent na", int'(act_na), VNA[k]);
            chk("R2 transparent nb", int'(act_nb), VNB[k]);
            chk("R10 range flag", int'(m_out_of_range), VOOR[k]);
            step();
        end

        // R3 capture and hold
        par_m = 9'd150; par_na = 2'd1; par_nb = 2'd2;
        step();
        par_load = 1'b1;
        step();
        par_m = 9'd300; par_na = 2'd3; par_nb = 2'd0;
        #2;
        chk("R3 held m", int'(act_m), 150);
        chk("R3 held na", int'(act_na), 1);
        step();
        chk("R3 still held nb", int'(act_nb), 2);
        chk("R3 still held m", int'(act_m), 150);

        // R4 / R5 / R6 serial word
        send_word(w2);
        chk("R4 shift leaves m", int'(act_m), 150);
        chk("R4 shift leaves sel", int'(act_sel), 0);
        pulse_xfer();
        chk_all("R5 R6 transfer", w2);

        // R7 serial ignored while strobe low
        par_load = 1'b0; par_m = 9'd200; par_na = 2'd0; par_nb = 2'd1;
        step();
        send_word(w3);
        pulse_xfer();
        chk("R7 sel kept", int'(act_sel), 10);
        chk("R7 transparent m", int'(act_m), 200);
        par_load = 1'b1;
        step();
        chk("R3 captured 200", int'(act_m), 200);
        pulse_xfer();
        chk_all("R7 shift reg unchanged", w2);

        // R8 capture and transfer in the same cycle
        send_word(w3);
        par_load = 1'b0; par_m = 9'd170; par_na = 2'd2; par_nb = 2'd3;
        step();
        par_load = 1'b1; ser_xfer = 1'b1;
        step();
        ser_xfer = 1'b0;
        step();
        chk("R8 parallel m wins", int'(act_m), 170);
        chk("R8 sel unchanged", int'(act_sel), 10);
        chk("R8 test unchanged", int'(act_test), 2);
        pulse_xfer();
        chk_all("R8 word still present", w3);

        // R9 shift and transfer in the same cycle
        for (int i = 20; i >= 1; i--) send_bit(w4[i]);
        pre = {w3[0], w4[20:1]};
        ser_data = w4[0]; ser_clk = 1'b1; ser_xfer = 1'b1;
        step();
        ser_clk = 1'b0; ser_xfer = 1'b0;
        step();
        chk_all("R9 pre-shift copy", pre);
        pulse_xfer();
        chk_all("R9 shift applied", w4);

        // R11 held levels act once
        ser_data = 1'b1; ser_clk = 1'b1;
        repeat (3) step();
        ser_clk = 1'b0;
        ser_xfer = 1'b1;
        repeat (3) step();
        ser_xfer = 1'b0;
        step();
        post = {w4[19:0], 1'b1};
        chk_all("R11 single shift", post);
        chk("R10 flag after transfer", int'(m_out_of_range),
            (post[8:0] < 9'd140 || post[8:0] > 9'd175) ? 1 : 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule